// File: doc/BRIEF.md
# Shift-Register Address FIFO with Keyed Removal

This block keeps the physical addresses of buffered cells in arrival order. It is a chain of register slots with the head at slot 0. A new address is written into the first empty slot. A transmit strobe takes the address at the head, reports it as freed, and moves every other entry one slot toward the head.

Besides head departure, any stored entry can be removed by its address value. The removal key is sent to every slot at once, and each slot compares the key with its own contents. The slot that matches, and every slot behind it, shifts one place toward the head. The slots ahead of the match keep their contents, so the gap closes in one cycle and the order of the other entries is unchanged.

Transmit has priority over removal. When both are requested in the same cycle, the removal is parked for one cycle and a busy flag is shown. A removal key that matches no stored entry changes nothing and raises a one-cycle miss flag.

Top module: `afq_top`

## Requirements
- R1: After synchronous reset the queue is empty: `count` is 0, `head_valid` is 0, and `tx_free_valid`, `rm_free_valid`, `rm_miss` and `rm_busy` are all 0.
- R2: When `enq_valid` is high and the queue is not full, `enq_addr` is appended behind the existing entries. `count` rises by one at the next edge, and `head_addr` always shows the oldest stored address while `head_valid` is 1.
- R3: A `tx_req` with a non-empty queue removes the head entry at the clock edge. In the cycle after that edge, `tx_free_valid` is 1 and `tx_free_addr` holds the departed address. The remaining entries keep their order. A `tx_req` on an empty queue does nothing.
- R4: A removal whose key equals a stored address deletes the entry nearest the head with that value and keeps the order of all other entries. `count` falls by one. In the cycle after the edge, `rm_free_valid` is 1 and `rm_free_addr` holds the key.
- R5: A removal whose key matches no stored address leaves the contents and `count` unchanged. `rm_miss` is 1 for exactly the cycle after that edge, and `rm_free_valid` stays 0.
- R6: If a removal is requested in a cycle where a transmit takes effect, the transmit happens first. The removal is held for one cycle, with `rm_busy` at 1 during that cycle, and is applied at the next edge that has no effective transmit. A new `rm_valid` that arrives while `rm_busy` is 1 is ignored.
- R7: An `enq_valid` while the queue holds DEPTH entries and nothing departs in that cycle is ignored. An enqueue in the same cycle as a departure (transmit or removal hit) is accepted, and the new address is placed last.
- R8: Empty slots never match a removal key. A removal on an empty queue reports a miss (R5), even when the key equals an address that was stored earlier and has since left.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enq_valid | input | 1 | Append `enq_addr` at the tail |
| enq_addr | input | 16 | Cell address to append |
| tx_req | input | 1 | Head cell is transmitted this cycle |
| rm_valid | input | 1 | Remove the entry whose value is `rm_addr` |
| rm_addr | input | 16 | Broadcast removal key |
| head_valid | output | 1 | Queue is not empty |
| head_addr | output | 16 | Oldest stored address |
| tx_free_valid | output | 1 | An address was freed by transmit at the last edge |
| tx_free_addr | output | 16 | Address freed by transmit |
| rm_free_valid | output | 1 | An address was freed by removal at the last edge |
| rm_free_addr | output | 16 | Address freed by removal |
| rm_miss | output | 1 | The last applied removal key matched nothing |
| rm_busy | output | 1 | A removal is held behind a transmit |
| count | output | 4 | Number of stored entries (width $clog2(DEPTH+1)) |

## Verification
The occupancy, head and busy outputs change at the edge that follows the stimulus, so the bench drives inputs at the falling edge and compares them against its model one time unit after the next rising edge. The freed-address and miss flags are registered. They are due one cycle after the edge that applied the operation, which for a deferred removal is one edge later than the request. The driver queues each such event when it drives the cycle that causes it. A monitor that samples one time unit after every rising edge takes the front event and compares its kind and address with what the block shows, and it reports any flag that appears with no event queued.

// File: rtl/afq_pkg.sv
package afq_pkg;
    localparam int ADDR_W = 16;

    typedef logic [ADDR_W-1:0] addr_t;

    typedef struct packed {
        logic  valid;
        addr_t addr;
    } slot_t;

    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_TX   = 2'd1,
        OP_RM   = 2'd2
    } op_e;

    function automatic logic key_hit(slot_t s, addr_t key);
        return s.valid && (s.addr == key);
    endfunction
endpackage

// File: rtl/afq_slot.sv
module afq_slot
    import afq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  shift_en,
    input  slot_t upper,
    input  logic  load_en,
    input  addr_t load_addr,
    input  addr_t key,
    output slot_t cur,
    output logic  hit
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= '0;
        end else if (load_en) begin
            cur <= '{valid: 1'b1, addr: load_addr};
        end else if (shift_en) begin
            cur <= upper;
        end
    end

    // empty slot never reports a match (R8)
    assign hit = key_hit(cur, key);
endmodule

// File: rtl/afq_ctrl.sv
module afq_ctrl
    import afq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  tx_req,
    input  logic  head_valid,
    input  addr_t head_addr,
    input  logic  rm_valid,
    input  addr_t rm_addr,
    input  logic  rm_hit,
    output logic  tx_go,
    output logic  do_rm,
    output addr_t key,
    output logic  rm_busy,
    output logic  tx_free_valid,
    output addr_t tx_free_addr,
    output logic  rm_free_valid,
    output addr_t rm_free_addr,
    output logic  rm_miss
);
    logic  pend_v;
    addr_t pend_a;
    logic  active;
    op_e   op;

    assign active  = pend_v || rm_valid;
    assign key     = pend_v ? pend_a : rm_addr;
    assign rm_busy = pend_v;

    always_comb begin
        if (tx_req && head_valid) op = OP_TX;
        else if (active)          op = OP_RM;
        else                      op = OP_IDLE;
    end

    assign tx_go = (op == OP_TX);
    assign do_rm = (op == OP_RM);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_v        <= 1'b0;
            pend_a        <= '0;
            tx_free_valid <= 1'b0;
            tx_free_addr  <= '0;
            rm_free_valid <= 1'b0;
            rm_free_addr  <= '0;
            rm_miss       <= 1'b0;
        end else begin
            pend_v        <= active && tx_go;
            if (active && tx_go) pend_a <= key;
            tx_free_valid <= tx_go;
            if (tx_go) tx_free_addr <= head_addr;
            rm_free_valid <= do_rm && rm_hit;
            if (do_rm && rm_hit) rm_free_addr <= key;
            rm_miss       <= do_rm && !rm_hit;
        end
    end

    p_miss_excl_r5: assert property (@(posedge clk) disable iff (rst)
        !(rm_miss && rm_free_valid));

    p_defer_r6: assert property (@(posedge clk) disable iff (rst)
        (tx_req && head_valid && (rm_valid || rm_busy)) |=> rm_busy);

    p_busy_one_cycle_r6: assert property (@(posedge clk) disable iff (rst)
        (rm_busy && !(tx_req && head_valid)) |=> !rm_busy);
endmodule

// File: rtl/afq_top.sv
module afq_top
    import afq_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enq_valid,
    input  logic [ADDR_W-1:0] enq_addr,
    input  logic              tx_req,
    input  logic              rm_valid,
    input  logic [ADDR_W-1:0] rm_addr,
    output logic              head_valid,
    output logic [ADDR_W-1:0] head_addr,
    output logic              tx_free_valid,
    output logic [ADDR_W-1:0] tx_free_addr,
    output logic              rm_free_valid,
    output logic [ADDR_W-1:0] rm_free_addr,
    output logic              rm_miss,
    output logic              rm_busy,
    output logic [CNT_W-1:0]  count
);
    slot_t             slots [DEPTH+1];
    logic [DEPTH-1:0]  hit;
    logic [DEPTH-1:0]  behind;
    logic [DEPTH-1:0]  shift;
    logic              tx_go, do_rm, rm_hit, depart, load;
    addr_t             key;
    logic [CNT_W-1:0]  base;

    assign slots[DEPTH] = '0;

    afq_ctrl u_ctrl (
        .clk(clk), .rst(rst), .tx_req(tx_req),
        .head_valid(head_valid), .head_addr(head_addr),
        .rm_valid(rm_valid), .rm_addr(rm_addr), .rm_hit(rm_hit),
        .tx_go(tx_go), .do_rm(do_rm), .key(key), .rm_busy(rm_busy),
        .tx_free_valid(tx_free_valid), .tx_free_addr(tx_free_addr),
        .rm_free_valid(rm_free_valid), .rm_free_addr(rm_free_addr),
        .rm_miss(rm_miss)
    );

    // prefix OR: a slot shifts on removal if it or any slot nearer the head matched
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            behind[i] = hit[i] || ((i > 0) ? behind[(i > 0) ? i-1 : 0] : 1'b0);
            shift[i]  = tx_go || (do_rm && behind[i]);
        end
    end

    assign rm_hit = behind[DEPTH-1];
    assign depart = tx_go || (do_rm && rm_hit);
    assign base   = count - CNT_W'(depart);
    assign load   = enq_valid && (base < CNT_W'(DEPTH));

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        afq_slot u_slot (
            .clk(clk), .rst(rst),
            .shift_en(shift[g]), .upper(slots[g+1]),
            .load_en(load && (base == CNT_W'(g))), .load_addr(enq_addr),
            .key(key), .cur(slots[g]), .hit(hit[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) count <= '0;
        else     count <= base + CNT_W'(load);
    end

    assign head_valid = slots[0].valid;
    assign head_addr  = slots[0].addr;

    p_count_bound_r7: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH));

    p_head_matches_count_r2: assert property (@(posedge clk) disable iff (rst)
        head_valid == (count != '0));

    p_tx_free_is_head_r3: assert property (@(posedge clk) disable iff (rst)
        (tx_req && head_valid) |=> (tx_free_valid && tx_free_addr == $past(head_addr)));

    p_miss_keeps_count_r5: assert property (@(posedge clk) disable iff (rst)
        (do_rm && !rm_hit && !enq_valid) |=> (count == $past(count)));

    for (genvar g = 0; g + 1 < DEPTH; g++) begin : g_chk
        p_contiguous_r2: assert property (@(posedge clk) disable iff (rst)
            slots[g+1].valid |-> slots[g].valid);
    end
endmodule

// File: tb/afq_top_test.sv
module afq_top_test;
    localparam int DEPTH = 8;
    localparam int CW    = $clog2(DEPTH + 1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic enq_valid = 0, tx_req = 0, rm_valid = 0;
    logic [15:0] enq_addr = '0, rm_addr = '0;
    logic head_valid, tx_free_valid, rm_free_valid, rm_miss, rm_busy;
    logic [15:0] head_addr, tx_free_addr, rm_free_addr;
    logic [CW-1:0] count;

    always #2.5 clk = ~clk;

    afq_top #(.DEPTH(DEPTH)) uut (
        .clk(clk), .rst(rst), .enq_valid(enq_valid), .enq_addr(enq_addr),
        .tx_req(tx_req), .rm_valid(rm_valid), .rm_addr(rm_addr),
        .head_valid(head_valid), .head_addr(head_addr),
        .tx_free_valid(tx_free_valid), .tx_free_addr(tx_free_addr),
        .rm_free_valid(rm_free_valid), .rm_free_addr(rm_free_addr),
        .rm_miss(rm_miss), .rm_busy(rm_busy), .count(count)
    );

    typedef struct { int kind; int addr; string tag; } ev_t; // kind 1 tx, 2 rm, 3 miss
    ev_t exp_q[$];
    int  model[$];
    bit  pend_v = 0;
    int  pend_a = 0;
    int  compared = 0, mismatched = 0;
    bit  done = 0;

    task automatic chk(string tag, int act, int exp, string what);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // monitor: registered event outputs checked against queued expectations
    always @(posedge clk) begin
        #1;
        if (!rst) begin
            int okind;
            int oaddr;
            okind = tx_free_valid ? 1 : rm_free_valid ? 2 : rm_miss ? 3 : 0;
            oaddr = tx_free_valid ? int'(tx_free_addr) : rm_free_valid ? int'(rm_free_addr) : 0;
            if (exp_q.size() > 0) begin
                ev_t e;
                e = exp_q.pop_front();
                chk(e.tag, okind, e.kind, "event kind");
                if (e.kind != 3) chk(e.tag, oaddr, e.addr, "freed address");
                else             chk(e.tag, int'(rm_free_valid), 0, "no free on miss");
            end else begin
                chk("R1", okind, 0, "unexpected event");
            end
        end
    end

    task automatic step(bit e, int ea, bit t, bit r, int ra, string tag);
        bit tx_go, active, hit;
        int key;
        @(negedge clk);
        enq_valid = e; enq_addr = 16'(ea); tx_req = t; rm_valid = r; rm_addr = 16'(ra);
        tx_go  = t && model.size() > 0;
        active = pend_v || r;
        key    = pend_v ? pend_a : ra;
        hit    = 0;
        if (tx_go) begin
            exp_q.push_back('{1, model[0], tag});
            void'(model.pop_front());
            pend_v = active;
            if (active) pend_a = key;
        end else if (active) begin
            pend_v = 0;
            foreach (model[i]) if (!hit && model[i] == key) begin
                hit = 1;
                model.delete(i);
            end
            exp_q.push_back(hit ? '{2, key, tag} : '{3, 0, tag});
        end
        if (e && model.size() < DEPTH) model.push_back(ea);
        @(posedge clk);
        #1;
        enq_valid = 0; tx_req = 0; rm_valid = 0;
        chk(tag, int'(count), model.size(), "count");
        chk(tag, int'(head_valid), int'(model.size() > 0), "head_valid");
        if (model.size() > 0) chk(tag, int'(head_addr), model[0], "head_addr");
        chk(tag, int'(rm_busy), int'(pend_v), "rm_busy");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk("R1", int'(count), 0, "count");
        chk("R1", int'(head_valid), 0, "head_valid");
        chk("R1", int'(tx_free_valid | rm_free_valid | rm_miss | rm_busy), 0, "flags");
        @(negedge clk); rst = 0;

        // R2 appends
        for (int i = 0; i < 5; i++) step(1, 'h1000 + i, 0, 0, 0, "R2");
        // R3 transmit
        step(0, 0, 1, 0, 0, "R3");
        // R4 removal in middle, at head, at tail
        step(0, 0, 0, 1, 'h1002, "R4");
        step(0, 0, 0, 1, 'h1001, "R4");
        step(0, 0, 0, 1, 'h1004, "R4");
        // R5 miss
        step(0, 0, 0, 1, 'hBEEF, "R5");
        // R6 transmit and removal together, then ignored removal while busy
        for (int i = 0; i < 4; i++) step(1, 'h2000 + i, 0, 0, 0, "R2");
        step(0, 0, 1, 1, 'h2002, "R6");
        step(0, 0, 0, 1, 'h2001, "R6");
        step(0, 0, 0, 0, 0, "R6");
        // R6 held removal stays held under back-to-back transmits
        step(0, 0, 1, 1, 'h2003, "R6");
        step(0, 0, 1, 0, 0, "R6");
        step(0, 0, 0, 0, 0, "R6");
        // R7 fill, overflow ignored, enqueue with departures accepted
        for (int i = 0; i < DEPTH; i++) step(1, 'h3000 + i, 0, 0, 0, "R7");
        step(1, 'h3F00, 0, 0, 0, "R7");
        step(1, 'h3F01, 1, 0, 0, "R7");
        step(1, 'h3F02, 0, 1, 'h3003, "R7");
        step(1, 'h3F03, 0, 1, 'h9999, "R7");
        // duplicate value: nearest-head copy removed (R4)
        step(0, 0, 1, 0, 0, "R4");
        step(1, 'h3005, 0, 0, 0, "R4");
        step(0, 0, 0, 1, 'h3005, "R4");
        // drain, transmit on empty, removal on empty (R8)
        for (int i = 0; i < DEPTH + 1; i++) step(0, 0, 1, 0, 0, "R3");
        step(0, 0, 0, 1, 'h3F02, "R8");
        step(0, 0, 1, 1, 'h1000, "R8");
        step(0, 0, 0, 0, 0, "R8");
        chk("R5", exp_q.size(), 0, "pending events");
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule